// File: doc/BRIEF.md
# Converter Handshake Sequencer

This block drives the control side of an external multi-input successive-approximation analog-to-digital converter. It issues the start pulse that also latches the converter's input address. It then follows the converter's end-of-conversion line through its fall and its rise. When the rise arrives, it drives the converter's output-enable and a one-cycle strobe that makes a downstream result latch transparent. Input selection, the latch itself and the analog part are outside the block.

A parameter chooses between two variants. In the manual variant the sequencer rests in an idle state until a request line (a debounced pushbutton) is pressed and released, and it performs one conversion per press. In the free-running variant there is no idle state and no use of the request line; the sequencer starts the next conversion as soon as the previous result has been stored. Both asynchronous inputs pass through flop synchronizers before the state logic sees them. The reset is asynchronous when asserted and is released in step with the clock.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While `rst_n` is low, `sc_o`, `oe_o` and `en_o` are all low, and they drop at once when reset is asserted. After release the manual variant rests idle, and the free-running variant raises `sc_o` within a few cycles without any request.
- R2: In the manual variant, `sc_o` stays low for as long as `go_i` (active high) stays low.
- R3: In the manual variant, a `go_i` press of H clock cycles gives an `sc_o` pulse of exactly H cycles. The sequencer leaves the start state only after the press ends.
- R4: In the free-running variant, every `sc_o` pulse lasts exactly one cycle.
- R5: After start, the sequencer waits for `eoc_i` to go low and then high. If `eoc_i` never falls, or never rises again, `oe_o` and `en_o` stay low. `sc_o` and `oe_o` are never high together.
- R6: `en_o` is high for exactly one cycle per conversion, always together with `oe_o`. It rises C+2 cycles after the rising edge of `sc_o`, where C is the number of cycles from that edge until `eoc_i` returns high (two synchronizer stages).
- R7: `oe_o` is high for exactly two consecutive cycles per conversion.
- R8: In the free-running variant, consecutive rising edges of `sc_o` are C+5 cycles apart.
- R9: In the manual variant, after the result has been stored, no further `sc_o` pulse occurs until `go_i` is pressed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer and converter clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| go_i | input | 1 | Conversion request, active high (manual variant only) |
| eoc_i | input | 1 | End-of-conversion line from the converter, asynchronous |
| sc_o | output | 1 | Start conversion / address latch pulse |
| oe_o | output | 1 | Converter output enable |
| en_o | output | 1 | Result latch transparency strobe |

## Verification
The manual variant is run through a table of requests that vary three things: the press length, the delay of the converter's end-of-conversion fall, and the conversion length. This separates a start pulse that follows the press from one of fixed width, and it shows that the strobe timing follows the end-of-conversion rise and not the start. A free-running instance runs alongside and is checked for single-cycle starts and for the loop period. Directed cases hold `eoc_i` high for good, or low for good, to show that no read happens without the full handshake. A reset asserted during a read shows that the outputs clear at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_START   = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_READ    = 3'd4,
    ST_STORE   = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic sc;
    logic oe;
    logic en;
  } seq_out_t;

  localparam seq_out_t SEQ_OUT_NONE = '{sc: 1'b0, oe: 1'b0, en: 1'b0};

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= src;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter bit CONTINUOUS = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go_s,
  input  logic     eoc_s,
  output seq_out_t out_o
);

  localparam seq_state_e RST_STATE = CONTINUOUS ? ST_STORE : ST_IDLE;
  localparam seq_state_e END_STATE = CONTINUOUS ? ST_START : ST_IDLE;

  seq_state_e state_q, state_d;
  logic       state_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (go_s) state_d = ST_START;
      ST_START:   if (CONTINUOUS || !go_s) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (!eoc_s) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (eoc_s) state_d = ST_READ;
      ST_READ:    state_d = ST_STORE;
      ST_STORE:   state_d = END_STATE;
      default:    state_d = RST_STATE;
    endcase
  end

  assign state_en = (state_d != state_q);

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RST_STATE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // output decode, strobe depends on input during the wait-high state
  always_comb begin
    out_o = SEQ_OUT_NONE;
    case (state_q)
      ST_START:   out_o.sc = 1'b1;
      ST_WAIT_HI: begin
        out_o.oe = eoc_s;
        out_o.en = eoc_s;
      end
      ST_READ:    out_o.oe = 1'b1;
      default:    out_o = SEQ_OUT_NONE;
    endcase
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter bit CONTINUOUS  = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic eoc_i,
  output logic sc_o,
  output logic oe_o,
  output logic en_o
);

  localparam int IN_W = 2;

  logic            rst_n_int;
  logic [IN_W-1:0] raw_in, sync_in;
  seq_out_t        ctl;

  adc_seq_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign raw_in = {eoc_i, go_i};

  // eoc idles high, request idles low
  adc_seq_sync #(
    .WIDTH   (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  adc_seq_fsm #(
    .CONTINUOUS (CONTINUOUS)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n_int),
    .go_s  (sync_in[0]),
    .eoc_s (sync_in[1]),
    .out_o (ctl)
  );

  assign sc_o = ctl.sc;
  assign oe_o = ctl.oe;
  assign en_o = ctl.en;

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter bit CONTINUOUS = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic sc_o,
  input logic oe_o,
  input logic en_o
);

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!sc_o && !oe_o && !en_o)); // R1

  AST_SC_OE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_o && oe_o)); // R5

  AST_EN_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> oe_o); // R6

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> (!en_o && oe_o)); // R6

  AST_OE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |=> oe_o); // R7

  AST_OE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $past(oe_o)) |=> !oe_o); // R7

  if (CONTINUOUS) begin : g_cont
    AST_SC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sc_o |=> !sc_o); // R4
  end

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .CONTINUOUS (CONTINUOUS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sc_o  (sc_o),
  .oe_o  (oe_o),
  .en_o  (en_o)
);

// File: tb/test_adc_conv_ctrl.sv
`timescale 1ns/1ps

module conv_model (
  input  logic clk,
  input  logic sc,
  input  int   fall_dly,
  input  int   conv_len,
  output logic eoc
);
  logic sc_q;
  logic busy;
  int   k;

  initial begin
    eoc  = 1'b1;
    sc_q = 1'b0;
    busy = 1'b0;
    k    = 0;
  end

  always @(negedge clk) begin
    sc_q <= sc;
    if (sc && !sc_q) begin
      busy <= 1'b1;
      k    <= 0;
    end else if (busy) begin
      k <= k + 1;
      if (k + 1 == fall_dly) eoc <= 1'b0;
      if (k + 1 == conv_len) begin
        eoc  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end
endmodule

module test_adc_conv_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic eoc_m, eoc_c;
  logic sc_m, oe_m, en_m, sc_c, oe_c, en_c;
  int   f_m = 3, c_m = 20;
  int   f_c = 4, c_c = 30;
  int   checks = 0, errors = 0;
  int   cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_ctrl #(.CONTINUOUS(1'b0)) i_adc_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .go_i(go), .eoc_i(eoc_m),
    .sc_o(sc_m), .oe_o(oe_m), .en_o(en_m));

  adc_conv_ctrl #(.CONTINUOUS(1'b1)) i_adc_conv_ctrl_cont (
    .clk(clk), .rst_n(rst_n), .go_i(1'b0), .eoc_i(eoc_c),
    .sc_o(sc_c), .oe_o(oe_c), .en_o(en_c));

  conv_model u_mdl_m (.clk(clk), .sc(sc_m), .fall_dly(f_m), .conv_len(c_m), .eoc(eoc_m));
  conv_model u_mdl_c (.clk(clk), .sc(sc_c), .fall_dly(f_c), .conv_len(c_c), .eoc(eoc_c));

  // monitors, sampled on the falling edge
  int   sc_cnt = 0, oe_cnt = 0, en_cnt = 0, sc_rise = 0, en_rise = 0;
  logic sc_p = 1'b0, en_p = 1'b0, clr = 1'b0;
  int   c_rise = 0, c_rise_prev = 0, c_sc_run = 0, c_sc_last = 0, c_oe_run = 0, c_oe_last = 0;
  logic c_sc_p = 1'b0, c_oe_p = 1'b0;

  always @(negedge clk) begin
    if (clr) begin
      sc_cnt = 0; oe_cnt = 0; en_cnt = 0;
    end
    if (sc_m) sc_cnt++;
    if (oe_m) oe_cnt++;
    if (en_m) en_cnt++;
    if (sc_m && !sc_p) sc_rise = cyc;
    if (en_m && !en_p) en_rise = cyc;
    sc_p = sc_m;
    en_p = en_m;
    if (sc_c && !c_sc_p) begin c_rise_prev = c_rise; c_rise = cyc; end
    if (sc_c) c_sc_run++; else if (c_sc_p) begin c_sc_last = c_sc_run; c_sc_run = 0; end
    if (oe_c) c_oe_run++; else if (c_oe_p) begin c_oe_last = c_oe_run; c_oe_run = 0; end
    c_sc_p = sc_c;
    c_oe_p = oe_c;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
  endtask

  task automatic press(input int h);
    @(negedge clk); go = 1'b1;
    repeat (h) @(negedge clk);
    go = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(6);
  endtask

  // press length, eoc fall delay, conversion length
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{
    '{1, 3, 20}, '{3, 5, 40}, '{5, 2, 64}, '{2, 10, 25}, '{4, 7, 50}
  };

  initial begin
    cycles(3);
    chk("R1 reset sc manual", sc_m, 0);
    chk("R1 reset oe manual", oe_m, 0);
    chk("R1 reset sc free", sc_c, 0);
    chk("R1 reset en free", en_c, 0);
    rst_n = 1'b1;
    clear_counts();
    cycles(30);
    chk("R2 idle without request", sc_cnt, 0);
    chk("R1 free-running starts alone", (c_rise > 0) ? 1 : 0, 1);

    for (int i = 0; i < NVEC; i++) begin
      clear_counts();
      f_m = VEC[i][1];
      c_m = VEC[i][2];
      press(VEC[i][0]);
      cycles(VEC[i][2] + 20);
      chk("R3 sc length follows press", sc_cnt, VEC[i][0]);
      chk("R7 oe cycles per conversion", oe_cnt, 2);
      chk("R6 en cycles per conversion", en_cnt, 1);
      chk("R6 en delay from sc rise", en_rise - sc_rise, VEC[i][2] + 2);
      cycles(25);
      chk("R9 no restart without press", sc_cnt, VEC[i][0]);
    end

    chk("R4 free-running sc width", c_sc_last, 1);
    chk("R7 free-running oe width", c_oe_last, 2);
    chk("R8 free-running period", c_rise - c_rise_prev, c_c + 5);
    f_c = 6; c_c = 45;
    cycles(150);
    chk("R8 free-running period long", c_rise - c_rise_prev, 50);

    // eoc never falls
    clear_counts();
    f_m = 1000000; c_m = 1000000;
    press(2);
    cycles(120);
    chk("R5 no read without eoc fall", oe_cnt + en_cnt, 0);
    chk("R5 start seen", sc_cnt, 2);
    do_reset();

    // eoc falls but never rises
    clear_counts();
    f_m = 3; c_m = 1000000;
    press(2);
    cycles(120);
    chk("R5 no read without eoc rise", oe_cnt + en_cnt, 0);
    do_reset();

    // reset during a read of the free-running instance
    f_c = 4; c_c = 30;
    @(negedge clk);
    while (!oe_c) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 outputs clear at once", {29'd0, sc_c, oe_c, en_c}, 0);
    cycles(2);
    rst_n = 1'b1;
    cycles(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule